// File: doc/BRIEF.md
# Register Write-Protection Key Gate

This block sits between a simple memory-mapped write bus and a configuration register file. It holds the write path of the protected registers closed until software writes two byte keys, in order, to one dedicated key register. While the path is closed, bus writes to the protected registers are dropped and a sticky flag records the loss. A wrong key at any point closes the path again. The usual way to close it on purpose is to write 0xFF.

For every bus write the block gives the register file a write strobe and a per-bit write mask. The tamper configuration register and a range of backup data registers accept writes at all times. The status register is partly exempt: while the path is closed, only its bits 13 to 8 can be written. Reads of the key register are flagged so that the read multiplexer returns zero for them.

Top module: `keylock_gate`

## Requirements
- R1: After reset the gate is closed (`unlocked` = 0) and `drop_seen` = 0.
- R2: A write of 0xCA to the key register, then a write of 0x53 to it with no other key write between, opens the gate. `unlocked` goes to 1 in the cycle after the 0x53 write.
- R3: A key write that does not match the expected key ends the sequence. CA,77,53 and CA,CA,53 both leave the gate closed.
- R4: A write of 0xFF to the key register while the gate is open closes it from the next cycle.
- R5: A write of 0xCA while the gate is open closes it and counts as the first key, so a single following 0x53 opens it again.
- R6: While the gate is closed, a write to a protected register gives `reg_we` = 0 and `reg_wmask` = 0. `drop_seen` goes to 1 in the next cycle and stays at 1 until reset.
- R7: While the gate is open, a write to a protected register gives `reg_we` = 1 and `reg_wmask` = all ones, and `drop_seen` stays 0.
- R8: While the gate is closed, a write to the status register (word address STAT_ADDR) gives `reg_we` = 1 and `reg_wmask` = 0x0000_3F00 (bits 13 to 8), and does not set `drop_seen`.
- R9: The tamper register (TAMP_ADDR) and the backup range BKP_BASE to BKP_BASE+BKP_COUNT-1 take writes with a full mask while closed. The address BKP_BASE+BKP_COUNT is protected.
- R10: A write to the key register never asserts `reg_we`. A read of the key register asserts `rd_zero`, and a read of any other address does not.
- R11: Keys are compared on `bus_wdata[7:0]` only. For example, 0x1CA counts as 0xCA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| reg_we | output | 1 | Qualified write strobe to the register file |
| reg_wmask | output | DATA_W | Per-bit write enable to the register file |
| rd_zero | output | 1 | Forces the read data to zero for the key register |
| unlocked | output | 1 | Protected registers are writable |
| drop_seen | output | 1 | Sticky: a protected write was dropped |

## Verification
The hardest case to reach is the relock that doubles as a first key: a 0xCA while the gate is open. It can only be seen by a following lone 0x53 that reopens the gate. The stimulus first opens the gate and then writes CA and 53 alone. The sticky drop flag would hide every later "no drop" check, so each scenario starts from a fresh reset. The backup range is probed at both ends and one word past its end.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    typedef enum logic [1:0] {
        KS_IDLE  = 2'd0,
        KS_FIRST = 2'd1,
        KS_OPEN  = 2'd2
    } key_state_e;

    typedef struct packed {
        key_state_e state;
    } key_regs_t;

    typedef struct packed {
        logic is_key;
        logic is_stat;
        logic is_free;
        logic is_prot;
    } addr_class_t;

    localparam logic [7:0] KEY_FIRST = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

endpackage

// File: rtl/keylock_fsm.sv
module keylock_fsm
    import keylock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       open
);
    key_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (key_wr) begin
            unique case (r_q.state)
                KS_IDLE:  r_d.state = (key_byte == KEY_FIRST) ? KS_FIRST : KS_IDLE;
                KS_FIRST: r_d.state = (key_byte == KEY_SECOND) ? KS_OPEN : KS_IDLE;
                KS_OPEN:  r_d.state = (key_byte == KEY_FIRST) ? KS_FIRST : KS_IDLE;
                default:  r_d.state = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: KS_IDLE};
        else        r_q <= r_d;
    end

    assign open = (r_q.state == KS_OPEN);
endmodule

// File: rtl/keylock_decode.sv
module keylock_decode
    import keylock_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int KEY_ADDR  = 'h24,
    parameter int STAT_ADDR = 'h0C,
    parameter int TAMP_ADDR = 'h40,
    parameter int BKP_BASE  = 'h50,
    parameter int BKP_COUNT = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_class_t       cls
);
    localparam int BKP_END = BKP_BASE + BKP_COUNT;

    logic in_bkp;

    always_comb begin
        in_bkp      = (int'(addr) >= BKP_BASE) && (int'(addr) < BKP_END);
        cls.is_key  = (int'(addr) == KEY_ADDR);
        cls.is_stat = (int'(addr) == STAT_ADDR);
        cls.is_free = in_bkp || (int'(addr) == TAMP_ADDR);
        cls.is_prot = !(cls.is_key || cls.is_stat || cls.is_free);
    end
endmodule

// File: rtl/keylock_qual.sv
module keylock_qual
    import keylock_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int STAT_LO = 8,
    parameter int STAT_HI = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              open,
    input  addr_class_t       cls,
    output logic              we,
    output logic [DATA_W-1:0] wmask,
    output logic              dropped
);
    logic [DATA_W-1:0] stat_free_mask;

    for (genvar b = 0; b < DATA_W; b++) begin : g_smask
        assign stat_free_mask[b] = (b >= STAT_LO) && (b <= STAT_HI);
    end

    logic drop_d, drop_q;

    always_comb begin
        we    = 1'b0;
        wmask = '0;
        if (wr && !cls.is_key) begin
            if (open || cls.is_free) begin
                we    = 1'b1;
                wmask = '1;
            end else if (cls.is_stat) begin
                we    = 1'b1;
                wmask = stat_free_mask;
            end
        end
        drop_d = drop_q || (wr && cls.is_prot && !open);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= 1'b0;
        else        drop_q <= drop_d;
    end

    assign dropped = drop_q;
endmodule

// File: rtl/keylock_gate.sv
module keylock_gate
    import keylock_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int KEY_ADDR  = 'h24,
    parameter int STAT_ADDR = 'h0C,
    parameter int TAMP_ADDR = 'h40,
    parameter int BKP_BASE  = 'h50,
    parameter int BKP_COUNT = 20,
    parameter int STAT_LO   = 8,
    parameter int STAT_HI   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wmask,
    output logic              rd_zero,
    output logic              unlocked,
    output logic              drop_seen
);
    addr_class_t cls;

    keylock_decode #(
        .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
        .TAMP_ADDR(TAMP_ADDR), .BKP_BASE(BKP_BASE), .BKP_COUNT(BKP_COUNT)
    ) u_dec (
        .addr(bus_addr),
        .cls (cls)
    );

    keylock_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (bus_wr && cls.is_key),
        .key_byte(bus_wdata[7:0]),
        .open    (unlocked)
    );

    keylock_qual #(
        .DATA_W(DATA_W), .STAT_LO(STAT_LO), .STAT_HI(STAT_HI)
    ) u_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .open   (unlocked),
        .cls    (cls),
        .we     (reg_we),
        .wmask  (reg_wmask),
        .dropped(drop_seen)
    );

    assign rd_zero = bus_rd && cls.is_key;
endmodule

// File: rtl/keylock_chk.sv
module keylock_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int KEY_ADDR = 'h24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wmask,
    input logic              rd_zero,
    input logic              unlocked,
    input logic              drop_seen
);
    logic kw;
    assign kw = bus_wr && (int'(bus_addr) == KEY_ADDR);

    // R3
    wrong_key_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kw && bus_wdata[7:0] != 8'h53) |=> !unlocked);

    // R2
    open_needs_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(kw && bus_wdata[7:0] == 8'h53));

    // R10
    key_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kw |-> !reg_we);

    // R7
    open_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && !kw) |-> (reg_we && reg_wmask == {DATA_W{1'b1}}));

    // R6
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_seen |=> drop_seen);

    // R10
    rdz_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |-> bus_rd);

    // R6
    mask_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |-> (reg_wmask == '0));
endmodule

bind keylock_gate keylock_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reg_we(reg_we),
    .reg_wmask(reg_wmask), .rd_zero(rd_zero), .unlocked(unlocked),
    .drop_seen(drop_seen)
);

// File: tb/tb_keylock_gate.sv
`timescale 1ns/1ps
module tb_keylock_gate;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] KA = 8'h24, SA = 8'h0C, TA = 8'h40, BB = 8'h50;
    localparam int BC = 20;
    localparam logic [7:0] PA = 8'h00, PC = 8'h08;

    logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic reg_we, rd_zero, unlocked, drop_seen;
    logic [31:0] reg_wmask;

    int checks = 0, errors = 0;
    logic we_s;
    logic [31:0] mk_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    keylock_gate dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reg_we(reg_we),
        .reg_wmask(reg_wmask), .rd_zero(rd_zero), .unlocked(unlocked),
        .drop_seen(drop_seen)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_wr = 0; bus_rd = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    // write in one cycle; samples combinational qualifier mid-cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        #1;
        we_s = reg_we; mk_s = reg_wmask;
        @(negedge clk);
        bus_wr = 0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 unlocked", unlocked, 0);
        chk("R1 drop_seen", drop_seen, 0);
    endtask

    task automatic t_open();
        do_reset();
        wr(KA, 32'hCA);
        chk("R2 closed after first", unlocked, 0);
        wr(KA, 32'h53);
        chk("R2 open after second", unlocked, 1);
        chk("R10 key write no we", we_s, 0);
        wr(PC, 32'h1234);
        chk("R7 we", we_s, 1);
        chk("R7 mask", mk_s, 32'hFFFF_FFFF);
        chk("R7 no drop", drop_seen, 0);
        wr(KA, 32'hFF);
        chk("R4 relock ff", unlocked, 0);
    endtask

    task automatic t_wrong();
        do_reset();
        wr(KA, 32'hCA); wr(KA, 32'h77); wr(KA, 32'h53);
        chk("R3 CA 77 53 closed", unlocked, 0);
        wr(KA, 32'hCA); wr(KA, 32'hCA); wr(KA, 32'h53);
        chk("R3 CA CA 53 closed", unlocked, 0);
        wr(KA, 32'h53);
        chk("R3 lone 53 closed", unlocked, 0);
        wr(KA, 32'h1CA); wr(KA, 32'hA53);
        chk("R11 upper bits ignored", unlocked, 1);
    endtask

    task automatic t_reopen();
        do_reset();
        wr(KA, 32'hCA); wr(KA, 32'h53);
        chk("R5 open", unlocked, 1);
        wr(KA, 32'hCA);
        chk("R5 CA relocks", unlocked, 0);
        wr(PA, 32'h1);
        chk("R5 write dropped after relock", we_s, 0);
        wr(KA, 32'h53);
        chk("R5 lone 53 reopens", unlocked, 1);
    endtask

    task automatic t_exempt();
        do_reset();
        wr(SA, 32'hFFFF_FFFF);
        chk("R8 stat we", we_s, 1);
        chk("R8 stat mask", mk_s, 32'h0000_3F00);
        wr(TA, 32'h5);
        chk("R9 tamper mask", mk_s, 32'hFFFF_FFFF);
        wr(BB, 32'h5);
        chk("R9 bkp first", mk_s, 32'hFFFF_FFFF);
        wr(BB + BC - 1, 32'h5);
        chk("R9 bkp last", mk_s, 32'hFFFF_FFFF);
        chk("R8 R9 no drop", drop_seen, 0);
        wr(BB + BC, 32'h5);
        chk("R9 past end protected", we_s, 0);
        chk("R9 past end drops", drop_seen, 1);
    endtask

    task automatic t_drop();
        do_reset();
        wr(PA, 32'hDEAD);
        chk("R6 we", we_s, 0);
        chk("R6 mask", mk_s, 0);
        chk("R6 drop set", drop_seen, 1);
        wr(KA, 32'hCA); wr(KA, 32'h53);
        wr(PA, 32'h1);
        chk("R6 drop sticky", drop_seen, 1);
    endtask

    task automatic t_read();
        do_reset();
        @(negedge clk);
        bus_rd = 1; bus_addr = KA; #1;
        chk("R10 key read zero", rd_zero, 1);
        bus_addr = PA; #1;
        chk("R10 other read", rd_zero, 0);
        bus_rd = 0;
    endtask

    initial begin
        fork
            begin
                t_reset(); t_open(); t_wrong(); t_reopen();
                t_exempt(); t_drop(); t_read();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule